// File: doc/BRIEF.md
# Configurable Asynchronous Frame Receiver

This block recovers asynchronous serial characters from a single line. It is driven by an oversampling tick that runs at sixteen times the bit rate. A three-bit format code sets the character layout:

- seven data bits with parity,
- eight data bits, with or without parity,
- nine data bits,
- eight data bits followed by an address-marker bit.

A two-bit length code sets the stop interval to a half, one, one and a half or two bit times. A separate input chooses odd or even parity.

Each completed character becomes one 10-bit result word. The received bits sit in the low end of the word. The parity error and the framing error are packed into the two upper bits. The word is offered on a valid/ready output that feeds a receive queue.

The output holds one word. `word_valid` stays high, with `word_data` unchanged, until the cycle in which `word_ready` is high. A new word can load in that same cycle. If a character finishes while the held word is still waiting, the new character is discarded and the held word is kept. The format, length and parity inputs must stay steady while a character is being received.

Top module: `frame_rx`

## Requirements
- R1: Format code 001 receives 8 data bits, least significant first, into word bits 7:0. Word bit 8 is 0 and no parity bit is expected on the line.
- R2: Format code 011 receives 7 data bits into word bits 6:0 and then one parity bit. Word bit 7 is 0 and word bit 8 is the parity error.
- R3: Format code 111 receives 8 data bits and then one parity bit. Word bit 8 is set when the parity check fails.
- R4: With `odd_par` at 0, the data bits plus the parity bit must hold an even number of ones. With `odd_par` at 1 they must hold an odd number. Any other count sets word bit 8 in the parity formats.
- R5: Format codes 100 and 101 receive 9 data bits, and the ninth bit lands in word bit 8. No parity bit is taken and no parity error is reported.
- R6: Stop code n (0 to 3) gives a stop interval of n+1 half-bit slots. The line is sampled 4 ticks into each slot. Word bit 9, the framing error, is set when any of those samples is low.
- R7: A line held low from the start bit through the first stop slot gives the word 0x200 in an 8-bit format. This is the break pattern: framing error set, all data bits zero.
- R8: A falling edge starts a character only if the line is still low at the 8th tick after the edge was detected. A shorter low pulse is dropped and produces no word.
- R9: While `rx_en` is 0 the receiver sits idle, abandons any character in progress and produces no word.
- R10: `word_valid` and `word_data` hold steady until `word_ready` is high. A character that completes while a word is held and not accepted is discarded.
- R11: The format codes 000, 010 and 110 behave as code 001.
- R12: After reset, `word_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input, idle high |
| tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_en | input | 1 | Receiver enable |
| mode | input | 3 | Character format code |
| stop_len | input | 2 | Stop interval code |
| odd_par | input | 1 | 1 selects odd parity, 0 even |
| word_data | output | 10 | {framing error, bit8/parity error, data[7:0]} |
| word_valid | output | 1 | Result word available |
| word_ready | input | 1 | Queue accepts the word |

## Verification
The bench builds the block with 16 ticks per bit and a two-stage input synchronizer, and it generates one tick every second clock. With this setting a full 12-bit character takes only a few hundred cycles. That makes room to cover every format code, all four stop lengths, both parity senses, a break, a rejected start glitch and a held output. The stop slot sampled at a quarter-bit offset can be made low on its own, so a framing error confined to the final half-bit of a two-bit stop interval can be exercised.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;
  localparam int WORD_W = 10;
  localparam int MAX_BITS = 9;

  typedef enum logic [2:0] {
    FMT_D8  = 3'b001,
    FMT_D7P = 3'b011,
    FMT_D9  = 3'b100,
    FMT_D8M = 3'b101,
    FMT_D8P = 3'b111
  } fmt_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [3:0] nbits;
    logic       has_par;
    logic [2:0] slots;
  } fmt_cfg_t;
endpackage

// File: rtl/frame_rx_fmt.sv
module frame_rx_fmt
  import frame_rx_pkg::*;
(
  input  logic [2:0] mode,
  input  logic [1:0] stop_len,
  output fmt_cfg_t   cfg
);
  always_comb begin
    cfg.slots = {1'b0, stop_len} + 3'd1;
    unique case (mode)
      FMT_D7P: begin cfg.nbits = 4'd7; cfg.has_par = 1'b1; end
      FMT_D8P: begin cfg.nbits = 4'd8; cfg.has_par = 1'b1; end
      FMT_D9,
      FMT_D8M: begin cfg.nbits = 4'd9; cfg.has_par = 1'b0; end
      default: begin cfg.nbits = 4'd8; cfg.has_par = 1'b0; end
    endcase
  end
endmodule

// File: rtl/frame_rx_sync.sv
module frame_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[i] <= 1'b1;
        else if (i == 0) pipe[i] <= d;
        else pipe[i] <= pipe[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate
  assign q = pipe[STAGES-1];
endmodule

// File: rtl/frame_rx_core.sv
module frame_rx_core
  import frame_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line,
  input  logic              tick,
  input  logic              rx_en,
  input  logic              odd_par,
  input  fmt_cfg_t          cfg,
  output logic              done,
  output logic [WORD_W-1:0] word,
  output logic              busy
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] START_LIM = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] BIT_LIM   = CW'(OVS - 1);
  localparam logic [CW-1:0] STOP0_LIM = CW'(OVS/2 + OVS/4 - 1);
  localparam logic [CW-1:0] SLOT_LIM  = CW'(OVS/2 - 1);

  rx_state_e           state;
  logic [CW-1:0]       cnt;
  logic [3:0]          idx;
  logic [2:0]          slot;
  logic [MAX_BITS-1:0] sh;
  logic                pbit;
  logic                ferr;

  logic [MAX_BITS-1:0] data_al;
  logic                fe_now;
  logic                pe;
  logic [CW-1:0]       stop_lim;

  always_comb begin
    data_al  = sh >> (4'(MAX_BITS) - cfg.nbits);
    fe_now   = ((slot == 3'd0) ? 1'b0 : ferr) | ~line;
    pe       = cfg.has_par & ((^data_al) ^ pbit ^ odd_par);
    stop_lim = (slot == 3'd0) ? STOP0_LIM : SLOT_LIM;
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
      slot  <= '0;
      sh    <= '0;
      pbit  <= 1'b0;
      ferr  <= 1'b0;
      done  <= 1'b0;
      word  <= '0;
    end else begin
      done <= 1'b0;
      if (!rx_en) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else if (tick) begin
        unique case (state)
          ST_IDLE: if (!line) begin
            state <= ST_START;
            cnt   <= '0;
          end
          ST_START: if (cnt == START_LIM) begin
            cnt   <= '0;
            idx   <= '0;
            state <= line ? ST_IDLE : ST_DATA;
          end else cnt <= cnt + 1'b1;
          ST_DATA: if (cnt == BIT_LIM) begin
            cnt <= '0;
            sh  <= {line, sh[MAX_BITS-1:1]};
            if (idx == cfg.nbits - 4'd1) begin
              slot  <= '0;
              state <= cfg.has_par ? ST_PAR : ST_STOP;
            end else idx <= idx + 1'b1;
          end else cnt <= cnt + 1'b1;
          ST_PAR: if (cnt == BIT_LIM) begin
            cnt   <= '0;
            pbit  <= line;
            slot  <= '0;
            state <= ST_STOP;
          end else cnt <= cnt + 1'b1;
          ST_STOP: if (cnt == stop_lim) begin
            cnt  <= '0;
            ferr <= fe_now;
            if (slot == cfg.slots - 3'd1) begin
              state <= ST_IDLE;
              done  <= 1'b1;
              word  <= {fe_now, data_al[8] | pe, data_al[7:0]};
            end else slot <= slot + 1'b1;
          end else cnt <= cnt + 1'b1;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import frame_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_line,
  input  logic        tick,
  input  logic        rx_en,
  input  logic [2:0]  mode,
  input  logic [1:0]  stop_len,
  input  logic        odd_par,
  output logic [9:0]  word_data,
  output logic        word_valid,
  input  logic        word_ready
);
  logic              line_s;
  fmt_cfg_t          cfg;
  logic              done;
  logic [WORD_W-1:0] word;
  logic              busy;

  frame_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(line_s)
  );

  frame_rx_fmt u_fmt (.mode(mode), .stop_len(stop_len), .cfg(cfg));

  frame_rx_core #(.OVS(OVS)) u_core (
    .clk(clk), .rst_n(rst_n), .line(line_s), .tick(tick), .rx_en(rx_en),
    .odd_par(odd_par), .cfg(cfg), .done(done), .word(word), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      word_data  <= '0;
    end else if (done && (!word_valid || word_ready)) begin
      word_valid <= 1'b1;
      word_data  <= word;
    end else if (word_ready) begin
      word_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_rx_chk.sv
module frame_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic [2:0] mode,
  input logic [9:0] word_data,
  input logic       word_valid,
  input logic       word_ready,
  input logic       busy
);
  // R10
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

  // R9
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !busy);

  // R1
  plain8_bit8_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(word_valid) && mode == 3'b001) |-> !word_data[8]);

  // R2
  seven_bit7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(word_valid) && mode == 3'b011) |-> !word_data[7]);

  // R11
  odd_code_bit8_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(word_valid) && (mode == 3'b000 || mode == 3'b010 || mode == 3'b110))
      |-> !word_data[8]);
endmodule

bind frame_rx frame_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .mode(mode),
  .word_data(word_data), .word_valid(word_valid),
  .word_ready(word_ready), .busy(busy)
);

// File: tb/frame_rx_test.sv
module frame_rx_test;
  localparam int TICK_DIV = 2;
  localparam int OVS      = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       tick = 1'b0;
  logic       rx_en = 1'b1;
  logic [2:0] mode = 3'b001;
  logic [1:0] stop_len = 2'b01;
  logic       odd_par = 1'b0;
  logic [9:0] word_data;
  logic       word_valid;
  logic       word_ready = 1'b1;

  int checks = 0;
  int fails  = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];

  frame_rx #(.OVS(OVS), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick(tick), .rx_en(rx_en),
    .mode(mode), .stop_len(stop_len), .odd_par(odd_par),
    .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready)
  );

  always #10 clk = ~clk;

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % TICK_DIV;
    tick <= (tdiv == 0);
  end

  task automatic check(input bit ok, input string tag,
                       input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard side
  always @(negedge clk) begin
    if (rst_n && word_valid && word_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R9/R10 unexpected word", word_data, 10'h000);
      else begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(word_data == e, t, word_data, e);
      end
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n * TICK_DIV) @(negedge clk);
  endtask

  function automatic logic good_par(input logic [8:0] d, input int n, input logic od);
    logic [8:0] m;
    m = (n == 7) ? (d & 9'h07F) : (d & 9'h0FF);
    return (^m) ^ od;
  endfunction

  task automatic send(input logic [2:0] m, input logic [1:0] st, input logic od,
                      input logic [8:0] d, input logic pb, input logic [3:0] sp,
                      input bit expect_it, input string tag);
    int n;
    bit hp;
    logic [8:0] dm;
    logic pe, fe;
    logic [9:0] e;
    case (m)
      3'b011: begin n = 7; hp = 1; end
      3'b111: begin n = 8; hp = 1; end
      3'b100, 3'b101: begin n = 9; hp = 0; end
      default: begin n = 8; hp = 0; end
    endcase
    dm = (n == 7) ? (d & 9'h07F) : (n == 8) ? (d & 9'h0FF) : d;
    pe = hp ? ((^dm) ^ pb ^ od) : 1'b0;
    fe = 1'b0;
    for (int k = 0; k <= int'(st); k++) if (!sp[k]) fe = 1'b1;
    e = {fe, (n == 9) ? dm[8] : pe, dm[7:0]};
    mode = m; stop_len = st; odd_par = od;
    if (expect_it) begin exp_q.push_back(e); tag_q.push_back(tag); end
    rx_line = 1'b0; wait_ticks(OVS);
    for (int i = 0; i < n; i++) begin rx_line = dm[i]; wait_ticks(OVS); end
    if (hp) begin rx_line = pb; wait_ticks(OVS); end
    for (int k = 0; k <= int'(st); k++) begin rx_line = sp[k]; wait_ticks(OVS/2); end
    rx_line = 1'b1;
    wait_ticks(2 * OVS);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R12
    check(word_valid == 1'b0, "R12 reset valid", {9'd0, word_valid}, 10'h000);
    rst_n = 1'b1;
    wait_ticks(OVS);

    send(3'b001, 2'b01, 1'b0, 9'h0A5, 1'b0, 4'hF, 1, "R1 8-bit A5");
    send(3'b001, 2'b01, 1'b0, 9'h03C, 1'b0, 4'hF, 1, "R1 8-bit 3C");
    send(3'b011, 2'b01, 1'b0, 9'h055, good_par(9'h055, 7, 0), 4'hF, 1, "R2 7-bit even ok");
    send(3'b011, 2'b01, 1'b0, 9'h013, ~good_par(9'h013, 7, 0), 4'hF, 1, "R2 7-bit parity err");
    send(3'b111, 2'b01, 1'b0, 9'h0C3, good_par(9'h0C3, 8, 0), 4'hF, 1, "R3 8-bit par ok");
    send(3'b111, 2'b01, 1'b0, 9'h0C3, ~good_par(9'h0C3, 8, 0), 4'hF, 1, "R3 8-bit par err");
    send(3'b111, 2'b01, 1'b1, 9'h081, good_par(9'h081, 8, 1), 4'hF, 1, "R4 odd par ok");
    send(3'b111, 2'b01, 1'b1, 9'h081, good_par(9'h081, 8, 0), 4'hF, 1, "R4 odd par err");
    send(3'b100, 2'b01, 1'b0, 9'h1AB, 1'b0, 4'hF, 1, "R5 9-bit");
    send(3'b101, 2'b01, 1'b0, 9'h0FE, 1'b0, 4'hF, 1, "R5 marker clear");
    send(3'b101, 2'b01, 1'b0, 9'h101, 1'b0, 4'hF, 1, "R5 marker set");
    send(3'b001, 2'b00, 1'b0, 9'h05A, 1'b0, 4'hF, 1, "R6 half stop");
    send(3'b001, 2'b10, 1'b0, 9'h05A, 1'b0, 4'h3, 1, "R6 1.5 stop err");
    send(3'b001, 2'b11, 1'b0, 9'h077, 1'b0, 4'h7, 1, "R6 2 stop late err");
    send(3'b001, 2'b11, 1'b0, 9'h077, 1'b0, 4'hF, 1, "R6 2 stop ok");
    send(3'b001, 2'b01, 1'b0, 9'h000, 1'b0, 4'hE, 1, "R7 break");
    send(3'b010, 2'b01, 1'b0, 9'h1E7, 1'b0, 4'hF, 1, "R11 code 010");
    send(3'b110, 2'b01, 1'b0, 9'h099, 1'b1, 4'hF, 1, "R11 code 110");

    // R8: short glitch, then a valid character
    rx_line = 1'b0; wait_ticks(3); rx_line = 1'b1; wait_ticks(2 * OVS);
    check(word_valid == 1'b0, "R8 glitch no word", {9'd0, word_valid}, 10'h000);
    send(3'b001, 2'b01, 1'b0, 9'h042, 1'b0, 4'hF, 1, "R8 after glitch");

    // R9: disabled receiver
    rx_en = 1'b0;
    send(3'b001, 2'b01, 1'b0, 9'h0F0, 1'b0, 4'hF, 0, "R9");
    check(word_valid == 1'b0, "R9 disabled no word", {9'd0, word_valid}, 10'h000);
    rx_en = 1'b1;
    wait_ticks(OVS);

    // R10: held word, second character dropped
    word_ready = 1'b0;
    send(3'b001, 2'b01, 1'b0, 9'h011, 1'b0, 4'hF, 1, "R10 held word");
    send(3'b001, 2'b01, 1'b0, 9'h022, 1'b0, 4'hF, 0, "R10");
    check(word_valid && word_data == 10'h011, "R10 hold first", word_data, 10'h011);
    word_ready = 1'b1;
    wait_ticks(OVS);
    check(exp_q.size() == 0, "R10 queue drained", 10'(exp_q.size()), 10'h000);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%03h expected=%03h", 10'h001, 10'h000);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule